// File: doc/BRIEF.md
# Timer Control Register Block with Keyed Bit Clearing

This block holds the control words of a multi-timer controller behind a small synchronous register bus. A 32-bit main control word and a 32-bit second control word can be read and written directly. The main word is registered and driven to the timer channels.

Bits of the main word can also be cleared through a mask. Writing a mask to the clear offset zeroes each main-word bit whose mask bit is 1. This only works while a one-bit clear-enable flag is set. Software turns the flag on or off by writing a command byte to a separate key offset. Any other byte leaves the flag as it was.

A read returns its data one cycle after the request. An access to an offset that is not mapped raises a one-cycle error pulse one cycle later. Only the clear offset is write-only: reading it counts as a bad access.

Top module: `tcr_top`

## Requirements
- R1: While reset is asserted and after its release, the main word, the second word, the clear-enable flag, the read data and the error output are all zero.
- R2: A write to 0x30 loads the main word and a write to 0x34 loads the second word. A read of either returns the stored value on `rd_data` in the cycle after the read.
- R3: A read of 0x38 returns the clear-enable flag in bit 0, with bits 31:1 zero, in the cycle after the read.
- R4: On a write to 0x38 the command byte is `wr_data[8:1]`. Byte 0xAE sets the flag to 1 and byte 0xEA sets it to 0. Every other byte, and every other bit of `wr_data`, leaves the flag unchanged.
- R5: While the flag is 1, a write to 0x3C sets the main word to its old value ANDed with the inverse of `wr_data`.
- R6: While the flag is 0, a write to 0x3C changes no state.
- R7: A read of 0x3C returns zero on `rd_data` and raises `bad_access`.
- R8: A read or write at any offset other than 0x30, 0x34, 0x38, or a write at 0x3C, raises `bad_access` in the cycle after the access. It changes no state, and the read data is zero.
- R9: `bad_access` is high for exactly one cycle per bad access and low in any cycle that follows a good access or an idle cycle.
- R10: `ctl_main` and `ctl_aux` come from registers. They change only on the clock edge after a write that targets them: 0x30 or 0x3C for `ctl_main`, 0x34 for `ctl_aux`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | Byte offset of the access |
| wr_en | input | 1 | Write request |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en`, zero otherwise |
| bad_access | output | 1 | One-cycle pulse after an access to an unmapped offset |
| ctl_main | output | 32 | Main control word to the timer channels |
| ctl_aux | output | 32 | Second control word to the timer channels |

## Verification
If the clear-enable flag holds the wrong value, it shows up one cycle after the next read of 0x38. Without such a read, it shows up one cycle after a mask write to 0x3C: `ctl_main` either loses bits it should keep or keeps bits it should lose. A wrong mask or merge in the clear path is visible on `ctl_main` on the edge right after the write. A wrong address decode shows up one cycle later as a missing or extra `bad_access` pulse, or as nonzero read data where zero is expected. The bench therefore compares every output in every cycle against its model. This catches each of these faults within one or two cycles of the access that exposes it.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
    parameter int unsigned DATA_W = 32;
    parameter int unsigned ADDR_W = 8;
    parameter int unsigned KEY_W  = 8;
    parameter int unsigned KEY_LSB = 1;

    localparam logic [ADDR_W-1:0] OFF_MAIN = ADDR_W'('h30);
    localparam logic [ADDR_W-1:0] OFF_AUX  = ADDR_W'('h34);
    localparam logic [ADDR_W-1:0] OFF_KEY  = ADDR_W'('h38);
    localparam logic [ADDR_W-1:0] OFF_CLR  = ADDR_W'('h3C);

    localparam logic [KEY_W-1:0] KEY_ARM    = KEY_W'('hAE);
    localparam logic [KEY_W-1:0] KEY_DISARM = KEY_W'('hEA);

    typedef struct packed {
        logic main;
        logic aux;
        logic key;
        logic clr;
    } sel_t;

    typedef struct packed {
        logic [DATA_W-1:0] main;
        logic [DATA_W-1:0] aux;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } regs_t;
endpackage

// File: rtl/tcr_decode.sv
module tcr_decode
    import tcr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output sel_t              wsel,
    output sel_t              rsel,
    output logic              bad
);
    sel_t hit;

    always_comb begin
        hit.main = (addr == OFF_MAIN);
        hit.aux  = (addr == OFF_AUX);
        hit.key  = (addr == OFF_KEY);
        hit.clr  = (addr == OFF_CLR);

        wsel = wr_en ? hit : '0;
        rsel = '0;
        if (rd_en) begin
            rsel.main = hit.main;
            rsel.aux  = hit.aux;
            rsel.key  = hit.key;
        end

        // the clear offset is write-only
        bad = (wr_en && (hit == '0))
           || (rd_en && !(hit.main || hit.aux || hit.key));
    end
endmodule

// File: rtl/tcr_key_arm.sv
module tcr_key_arm
    import tcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              armed
);
    logic armed_d, armed_q;
    logic [KEY_W-1:0] cmd;

    always_comb begin
        cmd     = wdata[KEY_LSB +: KEY_W];
        armed_d = armed_q;
        if (key_wr) begin
            if (cmd == KEY_ARM) begin
                armed_d = 1'b1;
            end else if (cmd == KEY_DISARM) begin
                armed_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= armed_d;
        end
    end

    assign armed = armed_q;
endmodule

// File: rtl/tcr_ctl_core.sv
module tcr_ctl_core
    import tcr_pkg::*;
(
    input  logic [DATA_W-1:0] main_q,
    input  logic [DATA_W-1:0] aux_q,
    input  sel_t              wsel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              armed,
    output logic [DATA_W-1:0] main_d,
    output logic [DATA_W-1:0] aux_d
);
    logic clr_go;
    assign clr_go = wsel.clr && armed;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        always_comb begin
            if (wsel.main) begin
                main_d[i] = wdata[i];
            end else if (clr_go && wdata[i]) begin
                main_d[i] = 1'b0;
            end else begin
                main_d[i] = main_q[i];
            end
        end
    end

    assign aux_d = wsel.aux ? wdata : aux_q;
endmodule

// File: rtl/tcr_top.sv
module tcr_top
    import tcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              bad_access,
    output logic [DATA_W-1:0] ctl_main,
    output logic [DATA_W-1:0] ctl_aux
);
    regs_t st_d, st_q;
    sel_t  wsel, rsel;
    logic  bad;
    logic  armed;
    logic [DATA_W-1:0] main_nx, aux_nx;

    tcr_decode u_dec (
        .addr  (addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .wsel  (wsel),
        .rsel  (rsel),
        .bad   (bad)
    );

    tcr_key_arm u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .key_wr (wsel.key),
        .wdata  (wr_data),
        .armed  (armed)
    );

    tcr_ctl_core u_core (
        .main_q (st_q.main),
        .aux_q  (st_q.aux),
        .wsel   (wsel),
        .wdata  (wr_data),
        .armed  (armed),
        .main_d (main_nx),
        .aux_d  (aux_nx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.main  = main_nx;
        st_d.aux   = aux_nx;
        st_d.err   = bad;
        st_d.rdata = '0;
        if (rsel.main) begin
            st_d.rdata = st_q.main;
        end else if (rsel.aux) begin
            st_d.rdata = st_q.aux;
        end else if (rsel.key) begin
            st_d.rdata = DATA_W'(armed);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data    = st_q.rdata;
    assign bad_access = st_q.err;
    assign ctl_main   = st_q.main;
    assign ctl_aux    = st_q.aux;
endmodule

// File: rtl/tcr_chk.sv
module tcr_chk
    import tcr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              bad_access,
    input logic [DATA_W-1:0] ctl_main,
    input logic              armed
);
    logic rd_ok, wr_ok, bad_now;
    assign rd_ok   = (addr == OFF_MAIN) || (addr == OFF_AUX) || (addr == OFF_KEY);
    assign wr_ok   = rd_ok || (addr == OFF_CLR);
    assign bad_now = (wr_en && !wr_ok) || (rd_en && !rd_ok);

    // R3
    key_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFF_KEY) |=>
            (rd_data[DATA_W-1:1] == '0) && (rd_data[0] == $past(armed)));

    // R4
    arm_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_KEY && wr_data[KEY_LSB +: KEY_W] == KEY_ARM) |=> armed);

    // R5
    masked_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_CLR && armed) |=>
            (ctl_main == ($past(ctl_main) & ~$past(wr_data))));

    // R6
    disarmed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_CLR && !armed) |=> $stable(ctl_main));

    // R8
    bad_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_now |=> bad_access);

    // R9
    no_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_now |=> !bad_access);

    // R10
    main_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == OFF_MAIN || addr == OFF_CLR)) |=> $stable(ctl_main));
endmodule

bind tcr_top tcr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .bad_access (bad_access),
    .ctl_main   (ctl_main),
    .armed      (armed)
);

// File: tb/tb_tcr_top.sv
module tb_tcr_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        bad_access;
    logic [31:0] ctl_main;
    logic [31:0] ctl_aux;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural expectation, valid after the next rising edge
    logic [31:0] m_main = '0, m_aux = '0, m_rd = '0;
    logic        m_flag = 1'b0, m_err = 1'b0;
    string       cur_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    tcr_top dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .bad_access(bad_access),
        .ctl_main(ctl_main), .ctl_aux(ctl_aux)
    );

    task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", cur_tag, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        cmp("ctl_main", ctl_main, m_main);
        cmp("ctl_aux", ctl_aux, m_aux);
        cmp("rd_data", rd_data, m_rd);
        cmp("bad_access", {31'b0, bad_access}, {31'b0, m_err});
    endtask

    // one bus cycle: check last result, drive new access, predict its result
    task automatic cyc(string tag, logic rn, logic [7:0] a, logic w, logic [31:0] d, logic r);
        @(negedge clk);
        check_outputs();
        cur_tag = tag;
        rst_n = rn; addr = a; wr_en = w; wr_data = d; rd_en = r;
        if (!rn) begin
            m_main = '0; m_aux = '0; m_rd = '0; m_flag = 0; m_err = 0;
        end else begin
            logic rd_good, wr_good;
            logic [31:0] rv;
            rd_good = (a == 8'h30) || (a == 8'h34) || (a == 8'h38);
            wr_good = rd_good || (a == 8'h3C);
            rv = '0;
            if (r && a == 8'h30) rv = m_main;
            if (r && a == 8'h34) rv = m_aux;
            if (r && a == 8'h38) rv = {31'b0, m_flag};
            m_err = (w && !wr_good) || (r && !rd_good);
            if (w) begin
                case (a)
                    8'h30: m_main = d;
                    8'h34: m_aux = d;
                    8'h38: begin
                        if (d[8:1] == 8'hAE) m_flag = 1;
                        else if (d[8:1] == 8'hEA) m_flag = 0;
                    end
                    8'h3C: if (m_flag) m_main = m_main & ~d;
                    default: ;
                endcase
            end
            m_rd = rv;
        end
    endtask

    task automatic wr(string tag, logic [7:0] a, logic [31:0] d); cyc(tag, 1, a, 1, d, 0); endtask
    task automatic rd(string tag, logic [7:0] a);                  cyc(tag, 1, a, 0, '0, 1); endtask
    task automatic idle(string tag);                               cyc(tag, 1, 8'h00, 0, '0, 0); endtask

    initial begin
        // R1 reset state
        cyc("R1", 0, 8'h30, 1, 32'hFFFF_FFFF, 0);
        cyc("R1", 0, 8'h00, 0, '0, 0);
        idle("R1");
        rd("R1", 8'h38);
        idle("R1");
        // R2 direct access
        wr("R2", 8'h30, 32'hFFFF_FFFF);
        rd("R2", 8'h30);
        wr("R2", 8'h34, 32'hA5A5_5A5A);
        rd("R2", 8'h34);
        // R6 clear while disarmed
        wr("R6", 8'h3C, 32'h0000_00FF);
        rd("R6", 8'h30);
        // R3 key register read
        rd("R3", 8'h38);
        // R4 arm with noise in other bits
        wr("R4", 8'h38, 32'hABCD_E000 | (32'hAE << 1) | 32'h1);
        rd("R4", 8'h38);
        wr("R4", 8'h38, 32'h57 << 1);
        rd("R4", 8'h38);
        wr("R4", 8'h38, 32'hAE);
        rd("R4", 8'h38);
        // R5 masked clear while armed
        wr("R5", 8'h3C, 32'h0F0F_0000);
        rd("R5", 8'h30);
        wr("R5", 8'h3C, 32'h8000_0001);
        wr("R5", 8'h3C, 32'h0);
        rd("R5", 8'h30);
        // R7 read of clear offset
        rd("R7", 8'h3C);
        rd("R7", 8'h3C);
        idle("R9");
        // R8 unmapped accesses
        wr("R8", 8'h40, 32'hFFFF_FFFF);
        rd("R8", 8'h00);
        wr("R8", 8'h31, 32'h0);
        idle("R9");
        rd("R8", 8'h30);
        // R4 disarm, then R6 again
        wr("R4", 8'h38, 32'hEA << 1);
        rd("R4", 8'h38);
        wr("R6", 8'h3C, 32'hFFFF_FFFF);
        rd("R6", 8'h30);
        // R10 mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [7:0] offs [6];
            logic [31:0] data;
            logic [2:0] pick;
            offs = '{8'h30, 8'h34, 8'h38, 8'h3C, 8'h44, 8'h38};
            pick = 3'($urandom_range(0, 5));
            data = $urandom;
            if ((i % 7) == 0) data = {$urandom_range(0, 1) ? (24'h0 | (32'hAE << 1)) : (24'h0 | (32'hEA << 1))};
            cyc("R10", 1, offs[pick], 1'($urandom_range(0, 1)), data, 1'($urandom_range(0, 1)));
        end
        idle("R10");
        @(negedge clk);
        check_outputs();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule